// File: doc/BRIEF.md
# Coarse-Grain Thread Switch Controller

This controller sits beside a single in-order pipeline that holds two hardware thread contexts but issues from only one at a time. The running context keeps the pipeline until it reports a long-latency miss, such as a miss in the second-level cache. The controller then records the faulting PC as that context's restart point and squashes everything in flight for a fixed penalty of four cycles. After the penalty it restarts fetch in the other context, provided that context is not itself still waiting on memory. Short stalls never reach this block, so they never cause a switch.

Each context has a waiting flag and a restart PC. A miss sets the flag and a per-context return strobe clears it. A context whose miss has come back becomes eligible again, but the controller does not preempt the running thread for it. The switch back happens only at the running thread's next long miss. If neither context is eligible when a flush ends, the pipeline idles with fetch off until the first return arrives. A redirect pulse then tells the front end which context to run and which PC to fetch from. Context 0 runs from its reset PC when reset releases.

Top module: `mt_switch_ctl`

## Requirements
- R1: During and right after reset, context 0 is active, fetch_en is 1, and flush and redir_vld are both 0.
- R2: A miss_valid sampled while fetch_en is 1 drives flush high for exactly FLUSH_CYC (4) consecutive cycles, starting in the following cycle. fetch_en is 0 for all of those cycles.
- R3: flush_mask equals pipe_vld in every flush cycle and is all zeros otherwise, so bit i marks pipeline stage i as squashed.
- R4: When a flush ends and the other context is not waiting, the cycle after the last flush cycle has fetch_en at 1, active_ctx at the other context and redir_vld high for one cycle. redir_pc holds that context's restart PC. A context that has never missed restarts at its reset PC (RST_PC0 or RST_PC1).
- R5: The restart PC stored for the missing context is the miss_pc sampled with its miss, so the faulting instruction runs again.
- R6: When a flush ends and the other context is still waiting, the block resumes the missing context if its own return has already arrived. Otherwise it idles with flush 0 and fetch_en 0. In the cycle after a return strobe is sampled, the idle state still holds. In the cycle after that, the returned context resumes with a redirect to its restart PC.
- R7: A return strobe for the idle context while the other context is running changes neither active_ctx nor redir_vld. That context becomes the switch target at the running context's next miss.
- R8: miss_valid is ignored while fetch_en is 0, both during a flush and while idle. It neither lengthens the flush nor starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| miss_valid | input | 1 | Long-latency miss reported by the running context |
| miss_pc | input | PC_W | PC of the instruction that missed |
| miss_ret | input | 2 | Per-context strobe: that context's outstanding miss has returned |
| pipe_vld | input | STAGES | Per-stage valid bits of the shared pipeline |
| flush | output | 1 | Squash in-flight work (switch penalty) |
| flush_mask | output | STAGES | Stages squashed in this cycle |
| active_ctx | output | 1 | Context that owns fetch and issue |
| redir_vld | output | 1 | One-cycle pulse: refetch from redir_pc |
| redir_pc | output | PC_W | Restart PC of the resuming context |
| fetch_en | output | 1 | Front end may fetch for active_ctx |

## Verification
The assertions assume three things about the inputs. miss_valid comes only from the running context. A context receives a return only while its miss is outstanding. A miss and a return for the same context never arrive in the same cycle. The directed tasks follow these rules. A miss is raised only when the bench's own model shows fetch enabled, or on purpose during a flush or idle period to show it is ignored. Each return strobe targets a context that the model marks as waiting, and each strobe lasts one cycle and is placed away from any miss on that context.

// File: rtl/mt_switch_pkg.sv
`timescale 1ns/1ps
// Shared types for the coarse-grain thread switch controller.
// Assumes exactly two hardware contexts; a context ID is one bit.
package mt_switch_pkg;
    localparam int NCTX = 2;

    typedef logic ctx_id_t;

    typedef enum logic [1:0] {
        SW_RUN   = 2'd0,
        SW_FLUSH = 2'd1,
        SW_STALL = 2'd2
    } sw_state_t;
endpackage

// File: rtl/mt_ctx_table.sv
`timescale 1ns/1ps
// Per-context waiting flag and restart PC.
// A set request marks one context as waiting and stores its restart PC.
// A return strobe clears that context's waiting flag.
// Assumes a set and a return never target the same context in one cycle;
// if they do, the set wins.
module mt_ctx_table #(
    parameter int              PC_W    = 32,
    parameter logic [PC_W-1:0] RST_PC0 = 32'h0000_1000,
    parameter logic [PC_W-1:0] RST_PC1 = 32'h0000_8000
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      set_en,
    input  mt_switch_pkg::ctx_id_t                    set_ctx,
    input  logic [PC_W-1:0]                           set_pc,
    input  logic [mt_switch_pkg::NCTX-1:0]            ret,
    output logic [mt_switch_pkg::NCTX-1:0]            waiting,
    output logic [mt_switch_pkg::NCTX-1:0][PC_W-1:0]  pc_tab
);
    import mt_switch_pkg::*;

    for (genvar k = 0; k < NCTX; k++) begin : g_ctx
        localparam logic [PC_W-1:0] BOOT_PC = (k == 0) ? RST_PC0 : RST_PC1;
        logic hit;

        // Set request aimed at this context
        always_comb hit = set_en && (set_ctx == ctx_id_t'(k));

        // Hold the waiting flag and restart PC of this context
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                waiting[k] <= 1'b0;
                pc_tab[k]  <= BOOT_PC;
            end else if (hit) begin
                waiting[k] <= 1'b1;
                pc_tab[k]  <= set_pc;
            end else if (ret[k]) begin
                waiting[k] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mt_flush_timer.sv
`timescale 1ns/1ps
// Fixed-length flush penalty counter.
// start loads FLUSH_CYC, and the count falls by one per cycle.
// last is high in the final penalty cycle.
// Assumes start is not raised again while a count is running.
module mt_flush_timer #(
    parameter int FLUSH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic last
);
    localparam int CNT_W = $clog2(FLUSH_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Load on start, count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (start)         cnt <= CNT_W'(FLUSH_CYC);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    // Final cycle of the penalty
    always_comb last = (cnt == CNT_W'(1));
endmodule

// File: rtl/mt_switch_ctl.sv
`timescale 1ns/1ps
// Coarse-grain thread switch controller for a two-context in-order pipeline.
// A long miss from the running context saves its PC and starts a fixed flush.
// After the flush, fetch moves to the other context if that context is
// eligible. Otherwise the missing context resumes if its own miss has
// returned, or the pipeline idles until a return arrives.
// Assumes miss_valid comes only from the running context and that
// miss_ret[k] is pulsed only while context k is waiting.
module mt_switch_ctl #(
    parameter int              PC_W      = 32,
    parameter int              FLUSH_CYC = 4,
    parameter int              STAGES    = 5,
    parameter logic [PC_W-1:0] RST_PC0   = 32'h0000_1000,
    parameter logic [PC_W-1:0] RST_PC1   = 32'h0000_8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [PC_W-1:0]   miss_pc,
    input  logic [1:0]        miss_ret,
    input  logic [STAGES-1:0] pipe_vld,
    output logic              flush,
    output logic [STAGES-1:0] flush_mask,
    output logic              active_ctx,
    output logic              redir_vld,
    output logic [PC_W-1:0]   redir_pc,
    output logic              fetch_en
);
    import mt_switch_pkg::*;

    sw_state_t                    state;
    ctx_id_t                      cur;
    ctx_id_t                      other;
    ctx_id_t                      pick;
    logic                         pick_ok;
    logic                         tmr_start;
    logic                         tmr_last;
    logic [NCTX-1:0]              ctx_wait;
    logic [NCTX-1:0][PC_W-1:0]    ctx_pc;

    // Accept a miss only while the running thread owns the pipeline
    always_comb tmr_start = (state == SW_RUN) && miss_valid;

    mt_ctx_table #(
        .PC_W    (PC_W),
        .RST_PC0 (RST_PC0),
        .RST_PC1 (RST_PC1)
    ) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (tmr_start),
        .set_ctx (cur),
        .set_pc  (miss_pc),
        .ret     (miss_ret),
        .waiting (ctx_wait),
        .pc_tab  (ctx_pc)
    );

    mt_flush_timer #(
        .FLUSH_CYC (FLUSH_CYC)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .last  (tmr_last)
    );

    // Pick the resume target: the other context first, then the missing one
    always_comb begin
        other   = ~cur;
        pick    = other;
        pick_ok = 1'b0;
        if (!ctx_wait[other]) begin
            pick    = other;
            pick_ok = 1'b1;
        end else if (!ctx_wait[cur]) begin
            pick    = cur;
            pick_ok = 1'b1;
        end
    end

    // Run / flush / idle sequencing and redirect generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SW_RUN;
            cur       <= 1'b0;
            redir_vld <= 1'b0;
            redir_pc  <= RST_PC0;
        end else begin
            redir_vld <= 1'b0;
            case (state)
                SW_RUN: begin
                    if (miss_valid) state <= SW_FLUSH;
                end
                SW_FLUSH: begin
                    if (tmr_last) begin
                        if (pick_ok) begin
                            state     <= SW_RUN;
                            cur       <= pick;
                            redir_vld <= 1'b1;
                            redir_pc  <= ctx_pc[pick];
                        end else begin
                            state <= SW_STALL;
                        end
                    end
                end
                SW_STALL: begin
                    if (pick_ok) begin
                        state     <= SW_RUN;
                        cur       <= pick;
                        redir_vld <= 1'b1;
                        redir_pc  <= ctx_pc[pick];
                    end
                end
                default: state <= SW_RUN;
            endcase
        end
    end

    // Output decode from the sequencing state
    always_comb begin
        flush      = (state == SW_FLUSH);
        fetch_en   = (state == SW_RUN);
        flush_mask = flush ? pipe_vld : '0;
        active_ctx = cur;
    end
endmodule

// File: rtl/mt_switch_chk.sv
`timescale 1ns/1ps
// Protocol checker for mt_switch_ctl, attached with bind.
// Assumes the input rules listed in the brief.
module mt_switch_chk #(
    parameter int FLUSH_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic miss_valid,
    input logic flush,
    input logic fetch_en,
    input logic redir_vld,
    input logic active_ctx
);
    localparam int LW = $clog2(FLUSH_CYC + 1) + 1;

    logic [LW-1:0] fl_len;
    logic          seen;

    // Length of the current flush run
    always_ff @(posedge clk) begin
        if (!rst_n)     fl_len <= '0;
        else if (flush) fl_len <= fl_len + 1'b1;
        else            fl_len <= '0;
    end

    // Marks that one cycle out of reset has passed
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    assert_miss_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && fetch_en) |=> flush);

    assert_flush_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (fl_len < LW'(FLUSH_CYC)));

    assert_flush_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush) |-> ($past(fl_len) == LW'(FLUSH_CYC - 1)));

    assert_no_fetch_in_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush && fetch_en));

    assert_redir_resume_R4: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld |-> (fetch_en && !$past(fetch_en)));

    assert_ctx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !redir_vld) |-> (active_ctx == $past(active_ctx)));

    assert_idle_no_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_en && !flush) |=> !flush);
endmodule

bind mt_switch_ctl mt_switch_chk #(
    .FLUSH_CYC (FLUSH_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .flush      (flush),
    .fetch_en   (fetch_en),
    .redir_vld  (redir_vld),
    .active_ctx (active_ctx)
);

// File: tb/sim_mt_switch_ctl.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario; inputs change and outputs are read at negedge.
module sim_mt_switch_ctl;
    localparam int          PC_W = 32;
    localparam int          ST   = 5;
    localparam logic [31:0] PC0  = 32'h0000_1000;
    localparam logic [31:0] PC1  = 32'h0000_8000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            miss_valid = 1'b0;
    logic [PC_W-1:0] miss_pc = '0;
    logic [1:0]      miss_ret = '0;
    logic [ST-1:0]   pipe_vld = '0;
    logic            flush;
    logic [ST-1:0]   flush_mask;
    logic            active_ctx;
    logic            redir_vld;
    logic [PC_W-1:0] redir_pc;
    logic            fetch_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mt_switch_ctl #(.PC_W(PC_W), .FLUSH_CYC(4), .STAGES(ST),
                    .RST_PC0(PC0), .RST_PC1(PC1)) u0 (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_pc(miss_pc),
        .miss_ret(miss_ret), .pipe_vld(pipe_vld), .flush(flush),
        .flush_mask(flush_mask), .active_ctx(active_ctx), .redir_vld(redir_vld),
        .redir_pc(redir_pc), .fetch_en(fetch_en));

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R1: state right after reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "fetch_en in reset", 64'(fetch_en), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "active_ctx", 64'(active_ctx), 64'd0);
        chk("R1", "fetch_en", 64'(fetch_en), 64'd1);
        chk("R1", "flush", 64'(flush), 64'd0);
        chk("R1", "redir_vld", 64'(redir_vld), 64'd0);
    endtask

    // Four flush cycles with mask checks; optional return strobe and ignored miss inside
    task automatic flush_window(input logic [ST-1:0] pv, input logic [1:0] ret0,
                                input bit pulse);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            miss_valid = (pulse && i == 1);
            miss_ret   = (i == 0) ? ret0 : 2'b00;
            chk("R2", "flush high", 64'(flush), 64'd1);
            chk("R2", "fetch_en low in flush", 64'(fetch_en), 64'd0);
            chk("R3", "flush_mask", 64'(flush_mask), 64'(pv));
        end
    endtask

    // R2 R3 R4 R5 R8: miss leads to a resume without idling
    task automatic t_miss_switch(input logic [31:0] pc, input logic [ST-1:0] pv,
                                 input logic ectx, input logic [31:0] epc,
                                 input logic [1:0] ret0, input bit pulse);
        @(negedge clk);
        chk("R2", "no flush before miss", 64'(flush), 64'd0);
        miss_valid = 1'b1; miss_pc = pc; pipe_vld = pv;
        flush_window(pv, ret0, pulse);
        @(negedge clk);
        miss_valid = 1'b0; miss_ret = 2'b00;
        chk("R2", "flush ends after 4", 64'(flush), 64'd0);
        chk("R3", "mask zero after flush", 64'(flush_mask), 64'd0);
        chk("R4", "fetch_en resumes", 64'(fetch_en), 64'd1);
        chk("R4", "active_ctx", 64'(active_ctx), 64'(ectx));
        chk("R4", "redir_vld", 64'(redir_vld), 64'd1);
        chk("R5", "redir_pc", 64'(redir_pc), 64'(epc));
        @(negedge clk);
        chk("R4", "redir pulse one cycle", 64'(redir_vld), 64'd0);
        chk("R8", "no second flush", 64'(flush), 64'd0);
    endtask

    // R6 R8: miss while the other context waits, idle until a return
    task automatic t_miss_stall(input logic [31:0] pc, input int rctx,
                                input logic [31:0] epc);
        @(negedge clk);
        miss_valid = 1'b1; miss_pc = pc; pipe_vld = 5'b00101;
        flush_window(5'b00101, 2'b00, 1'b0);
        @(negedge clk);
        chk("R6", "idle no flush", 64'(flush), 64'd0);
        chk("R6", "idle no fetch", 64'(fetch_en), 64'd0);
        miss_valid = 1'b1;
        @(negedge clk);
        miss_valid = 1'b0;
        chk("R8", "miss ignored when idle", 64'(flush), 64'd0);
        chk("R6", "still idle", 64'(fetch_en), 64'd0);
        miss_ret[rctx] = 1'b1;
        @(negedge clk);
        miss_ret = 2'b00;
        chk("R6", "idle in cycle after return", 64'(fetch_en), 64'd0);
        @(negedge clk);
        chk("R6", "resume fetch", 64'(fetch_en), 64'd1);
        chk("R6", "resume ctx", 64'(active_ctx), 64'(rctx));
        chk("R6", "resume redir_vld", 64'(redir_vld), 64'd1);
        chk("R6", "resume pc", 64'(redir_pc), 64'(epc));
    endtask

    // R7: return while the other context runs does not preempt
    task automatic t_return_no_switch(input int rctx, input logic exp_ctx);
        @(negedge clk);
        miss_ret[rctx] = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            miss_ret = 2'b00;
            chk("R7", "ctx unchanged", 64'(active_ctx), 64'(exp_ctx));
            chk("R7", "no redirect", 64'(redir_vld), 64'd0);
            chk("R7", "fetch stays on", 64'(fetch_en), 64'd1);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        // ctx0 misses; ctx1 never missed, restarts at its reset PC
        t_miss_switch(32'h100, 5'b10110, 1'b1, PC1, 2'b00, 1'b0);
        // ctx1 misses while ctx0 waits: idle, then ctx0 returns
        t_miss_stall(32'h200, 0, 32'h100);
        // ctx1 returns while ctx0 runs; next ctx0 miss goes to ctx1 (ignored pulse in flush)
        t_return_no_switch(1, 1'b0);
        t_miss_switch(32'h140, 5'b00011, 1'b1, 32'h200, 2'b00, 1'b1);
        // ctx1 misses, its own return arrives during flush, ctx0 still waiting
        t_miss_switch(32'h300, 5'b11111, 1'b1, 32'h300, 2'b10, 1'b0);
        // ctx0 returns while ctx1 runs; next miss switches to ctx0
        t_return_no_switch(0, 1'b1);
        t_miss_switch(32'h380, 5'b01000, 1'b0, 32'h140, 2'b00, 1'b0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule